// File: doc/BRIEF.md
# Register-Pair Operand Access Unit

This unit sits between instruction decode and the 32-entry by 32-bit general register file of a 32-bit core. It lets 64-bit floating-point and 64-bit integer operations work on pairs of 32-bit registers. Each of the three operand slots (destination, source A, source B) gets a 5-bit base register index and a 1-bit spacing flag. The flag chooses whether the partner register is the next register or the one after it. The unit forms both indices, reads both registers, and joins them into a 64-bit operand for an external execution port. When the result comes back, it splits the result across the destination pair. It also rejects malformed encodings.

Only one instruction is handled at a time. The decode stage presents `dec_valid`, `dec_insn` and an operation class `dec_op`, and the unit accepts it when `dec_ready` is high. A state machine steps through four states:

- `ST_IDLE` waits for an instruction.
- `ST_EXEC` holds the operands on the execution port until `ex_done` arrives.
- `ST_WR_HI` writes the upper half of the result.
- `ST_WR_LO` writes the lower half of the result.

The transitions are:

- accept-legal: `ST_IDLE` to `ST_EXEC`.
- accept-illegal: `ST_IDLE` back to `ST_IDLE`, with a trap pulse.
- done-compare: `ST_EXEC` to `ST_IDLE`.
- done-write: `ST_EXEC` to `ST_WR_HI`.
- `ST_WR_HI` always moves to `ST_WR_LO`.
- `ST_WR_LO` always returns to `ST_IDLE`.

The register file has a single write port, so the two halves are written in consecutive cycles. `dec_ready` stays low until both halves are written. A later instruction therefore always reads the updated pair.

Top module: `regpair_operand_unit`

## Requirements
- R1: Instruction fields: the destination base index is in bits 25:21, source A in bits 20:16 and source B in bits 15:11. The spacing flags are bit 10 for the destination, bit 9 for A and bit 8 for B. The low register of a pair is the base index. The partner register is base+1 when the flag is 0 and base+2 when it is 1.
- R2: A 64-bit operand is {reg[base], reg[partner]}: the base register supplies bits 63:32.
- R3: Writeback places result bits 63:32 in the destination base register and bits 31:0 in its partner. Writeback occurs for every class except compare. The two writes occupy the two cycles that follow the `ex_done` cycle, and `dec_ready` stays low during both.
- R4: Operation class codes on `dec_op` are 0 arithmetic, 1 multiply-add, 2 compare, 3 int-to-float and 4 float-to-int. For multiply-add, the destination pair is presented on `ex_src_c` and the result returns to that same pair. For every other class, `ex_src_c` is zero.
- R5: Compare requires the destination field and bit 10 to be zero. Compare writes no register. On `ex_done`, `ex_flag` is latched into `cmp_flag`, and `dec_ready` returns high in the next cycle.
- R6: Conversions (codes 3 and 4) require the B field and bit 8 to be zero. They do not use source B, so `ex_src_b` is zero. The A pair (int-to-float) or the destination pair (float-to-int) is handled as a 64-bit integer exactly like any other pair.
- R7: An instruction is illegal, and trapped, in any of these cases:
  - a used operand's partner index exceeds 31;
  - a reserved bit or field is non-zero;
  - the class code is above 4.
  A trapped instruction raises `trap_illegal` for exactly the cycle after acceptance, starts no execution and writes no register.
- R8: An instruction is accepted on a clock edge with `dec_valid` and `dec_ready` both high. From the next cycle, `ex_valid` is high with stable operands and `ex_op` until the cycle of `ex_done`. `dec_ready` is low whenever `ex_valid` is high.
- R9: After reset, `dec_ready` is 1, and `ex_valid`, `trap_illegal` and `cmp_flag` are 0. All registers read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_insn | input | 32 | Instruction word |
| dec_op | input | 3 | Operation class code |
| dec_ready | output | 1 | Unit can accept (low = stall) |
| trap_illegal | output | 1 | One-cycle illegal-encoding pulse |
| ex_valid | output | 1 | Operands valid on execution port |
| ex_op | output | 3 | Class of the executing instruction |
| ex_src_a | output | 64 | Source A pair |
| ex_src_b | output | 64 | Source B pair (zero if unused) |
| ex_src_c | output | 64 | Destination pair read for multiply-add (else zero) |
| ex_done | input | 1 | Execution finished this cycle |
| ex_result | input | 64 | 64-bit result to write back |
| ex_flag | input | 1 | Compare outcome |
| cmp_flag | output | 1 | Latched compare status |

## Verification
The bench concentrates on the spacing flags. It uses pairs with spacing two, where a design that ignored the flag, or took it from the wrong bit, would read or write the neighbouring register and corrupt the skipped one. It exercises the partner index at exactly 31 and at 32. A design with an off-by-one range check would either trap a legal instruction or silently wrap to register 0. Each reserved-field case of compare and conversion is exercised, and every trap is followed by a read-back; a design that leaked a write or an execution on illegal input would show a changed pair or a raised `ex_valid`. Multiply-add checks that the accumulator pair arrives on `ex_src_c` and is overwritten in place. It also checks the half order, so swapped halves would show up.

// File: rtl/regpair_pkg.sv
package regpair_pkg;
    localparam int XLEN      = 32;
    localparam int IDX_W     = 5;
    localparam int NREGS     = 1 << IDX_W;
    localparam int NOPER     = 3;            // destination, A, B
    localparam int FIELD_TOP = 25;           // MSB of destination field
    localparam int FLAG_TOP  = 10;           // destination spacing flag

    localparam logic [2:0] OP_ARITH = 3'd0;
    localparam logic [2:0] OP_MADD  = 3'd1;
    localparam logic [2:0] OP_CMP   = 3'd2;
    localparam logic [2:0] OP_ITOF  = 3'd3;
    localparam logic [2:0] OP_FTOI  = 3'd4;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_EXEC,
        ST_WR_HI,
        ST_WR_LO
    } state_e;

    typedef struct packed {
        logic [IDX_W-1:0] lo;
        logic [IDX_W:0]   hi;    // one extra bit to detect overflow
        logic [IDX_W-1:0] base;
        logic             flag;
    } pair_t;
endpackage

// File: rtl/regpair_decode.sv
module regpair_decode
    import regpair_pkg::*;
(
    input  logic [31:0] insn,
    input  logic [2:0]  op,
    output pair_t       pairs [NOPER],
    output logic        use_b,
    output logic        use_c,
    output logic        legal
);
    for (genvar g = 0; g < NOPER; g++) begin : g_pair
        localparam int LSB  = FIELD_TOP - IDX_W + 1 - IDX_W * g;
        localparam int FBIT = FLAG_TOP - g;
        always_comb begin
            pairs[g].base = insn[LSB +: IDX_W];
            pairs[g].flag = insn[FBIT];
            pairs[g].lo   = insn[LSB +: IDX_W];
            pairs[g].hi   = {1'b0, insn[LSB +: IDX_W]} + (insn[FBIT] ? 6'd2 : 6'd1);
        end
    end

    logic is_cmp, is_conv, use_d, bad_op, bad_range, bad_resv;

    always_comb begin
        is_cmp    = (op == OP_CMP);
        is_conv   = (op == OP_ITOF) || (op == OP_FTOI);
        bad_op    = (op > OP_FTOI);
        use_d     = !is_cmp;
        use_b     = !is_conv;
        use_c     = (op == OP_MADD);
        bad_range = pairs[1].hi[IDX_W]
                  | (use_d & pairs[0].hi[IDX_W])
                  | (use_b & pairs[2].hi[IDX_W]);
        bad_resv  = (is_cmp  & ((pairs[0].base != '0) | pairs[0].flag))
                  | (is_conv & ((pairs[2].base != '0) | pairs[2].flag));
        legal     = !(bad_op | bad_range | bad_resv);
    end
endmodule

// File: rtl/regpair_regfile.sv
module regpair_regfile #(
    parameter int DW  = 32,
    parameter int AW  = 5,
    parameter int NRD = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NRD-1:0][AW-1:0] rd_addr,
    output logic [NRD-1:0][DW-1:0] rd_data,
    input  logic                   we,
    input  logic [AW-1:0]          wr_addr,
    input  logic [DW-1:0]          wr_data
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (we) begin
            mem[wr_addr] <= wr_data;
        end
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rd_data[p] = mem[rd_addr[p]];
    end
endmodule

// File: rtl/regpair_operand_unit.sv
module regpair_operand_unit
    import regpair_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    input  logic [31:0]       dec_insn,
    input  logic [2:0]        dec_op,
    output logic              dec_ready,
    output logic              trap_illegal,
    output logic              ex_valid,
    output logic [2:0]        ex_op,
    output logic [2*XLEN-1:0] ex_src_a,
    output logic [2*XLEN-1:0] ex_src_b,
    output logic [2*XLEN-1:0] ex_src_c,
    input  logic              ex_done,
    input  logic [2*XLEN-1:0] ex_result,
    input  logic              ex_flag,
    output logic              cmp_flag
);
    localparam int NRD = 2 * NOPER;

    pair_t pairs [NOPER];
    logic  use_b, use_c, legal;

    regpair_decode u_dec (
        .insn  (dec_insn),
        .op    (dec_op),
        .pairs (pairs),
        .use_b (use_b),
        .use_c (use_c),
        .legal (legal)
    );

    logic [NRD-1:0][IDX_W-1:0] rd_addr;
    logic [NRD-1:0][XLEN-1:0]  rd_data;
    logic                      rf_we;
    logic [IDX_W-1:0]          rf_waddr;
    logic [XLEN-1:0]           rf_wdata;

    for (genvar g = 0; g < NOPER; g++) begin : g_addr
        assign rd_addr[2*g]   = pairs[g].lo;
        assign rd_addr[2*g+1] = pairs[g].hi[IDX_W-1:0];
    end

    regpair_regfile #(.DW(XLEN), .AW(IDX_W), .NRD(NRD)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .we      (rf_we),
        .wr_addr (rf_waddr),
        .wr_data (rf_wdata)
    );

    state_e            state, state_nx;
    logic              accept;
    logic [IDX_W-1:0]  dst_lo, dst_hi;
    logic [2*XLEN-1:0] res_q;

    assign accept = dec_valid && (state == ST_IDLE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (accept && legal) state_nx = ST_EXEC;
            ST_EXEC:  if (ex_done) state_nx = (ex_op == OP_CMP) ? ST_IDLE : ST_WR_HI;
            ST_WR_HI: state_nx = ST_WR_LO;
            ST_WR_LO: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trap_illegal <= 1'b0;
            ex_op        <= '0;
            ex_src_a     <= '0;
            ex_src_b     <= '0;
            ex_src_c     <= '0;
            dst_lo       <= '0;
            dst_hi       <= '0;
            res_q        <= '0;
            cmp_flag     <= 1'b0;
        end else begin
            trap_illegal <= accept && !legal;
            if (accept && legal) begin
                ex_op    <= dec_op;
                ex_src_a <= {rd_data[2], rd_data[3]};
                ex_src_b <= use_b ? {rd_data[4], rd_data[5]} : '0;
                ex_src_c <= use_c ? {rd_data[0], rd_data[1]} : '0;
                dst_lo   <= pairs[0].lo;
                dst_hi   <= pairs[0].hi[IDX_W-1:0];
            end
            if (state == ST_EXEC && ex_done) begin
                if (ex_op == OP_CMP) cmp_flag <= ex_flag;
                else                 res_q    <= ex_result;
            end
        end
    end

    // outputs
    always_comb begin
        dec_ready = 1'b0;
        ex_valid  = 1'b0;
        rf_we     = 1'b0;
        rf_waddr  = dst_lo;
        rf_wdata  = res_q[2*XLEN-1:XLEN];
        unique case (state)
            ST_IDLE:  dec_ready = 1'b1;
            ST_EXEC:  ex_valid  = 1'b1;
            ST_WR_HI: rf_we     = 1'b1;
            ST_WR_LO: begin
                rf_we    = 1'b1;
                rf_waddr = dst_hi;
                rf_wdata = res_q[XLEN-1:0];
            end
            default: ;
        endcase
    end

    assert_trap_no_exec_R7: assert property (@(posedge clk) disable iff (!rst_n)
        trap_illegal |-> !ex_valid && $past(state) == ST_IDLE);

    assert_stall_when_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ex_valid |-> !dec_ready);

    assert_operands_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && !ex_done) |=> ex_valid && $stable(ex_src_a) && $stable(ex_src_b)
                                   && $stable(ex_src_c) && $stable(ex_op));

    assert_two_write_cycles_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WR_HI) |=> (state == ST_WR_LO) && !dec_ready);

    assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_done && ex_op == OP_CMP) |=> dec_ready && !rf_we);

    assert_conv_no_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && (ex_op == OP_ITOF || ex_op == OP_FTOI)) |-> ex_src_b == '0);
endmodule

// File: tb/sim_regpair_operand_unit.sv
module sim_regpair_operand_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dec_valid = 1'b0;
    logic [31:0] dec_insn = '0;
    logic [2:0]  dec_op = '0;
    logic        dec_ready, trap_illegal, ex_valid, cmp_flag;
    logic [2:0]  ex_op;
    logic [63:0] ex_src_a, ex_src_b, ex_src_c;
    logic        ex_done = 1'b0;
    logic [63:0] ex_result = '0;
    logic        ex_flag = 1'b0;

    int checks = 0;
    int errors = 0;
    logic [31:0] mrf [32];

    regpair_operand_unit u0 (
        .clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_insn(dec_insn),
        .dec_op(dec_op), .dec_ready(dec_ready), .trap_illegal(trap_illegal),
        .ex_valid(ex_valid), .ex_op(ex_op), .ex_src_a(ex_src_a), .ex_src_b(ex_src_b),
        .ex_src_c(ex_src_c), .ex_done(ex_done), .ex_result(ex_result),
        .ex_flag(ex_flag), .cmp_flag(cmp_flag)
    );

    always #10 clk = ~clk;

    task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] enc(int d, int doff, int a, int aoff, int b, int boff);
        logic [31:0] w = '0;
        w[25:21] = d[4:0]; w[20:16] = a[4:0]; w[15:11] = b[4:0];
        w[10] = doff[0]; w[9] = aoff[0]; w[8] = boff[0];
        return w;
    endfunction

    function automatic logic [63:0] mpair(int base, int off);
        return {mrf[base], mrf[base + 1 + off]};
    endfunction

    // Issue a legal instruction, check operands, return result, check writeback timing.
    task automatic run_op(logic [2:0] op, int d, int doff, int a, int aoff, int b, int boff,
                          logic [63:0] res, logic flg);
        logic [63:0] ea, eb, ec;
        @(negedge clk);
        check("R8", "ready before issue", dec_ready, 1);
        dec_valid = 1; dec_op = op; dec_insn = enc(d, doff, a, aoff, b, boff);
        ea = mpair(a, aoff);
        eb = (op == 3 || op == 4) ? 64'h0 : mpair(b, boff);
        ec = (op == 1) ? mpair(d, doff) : 64'h0;
        @(negedge clk);
        dec_valid = 0;
        check("R8", "ex_valid", ex_valid, 1);
        check("R8", "stall in exec", dec_ready, 0);
        check("R8", "ex_op", ex_op, op);
        check("R2", "src A pair", ex_src_a, ea);
        check((op == 3 || op == 4) ? "R6" : "R1", "src B pair", ex_src_b, eb);
        check("R4", "src C pair", ex_src_c, ec);
        ex_done = 1; ex_result = res; ex_flag = flg;
        @(negedge clk);
        ex_done = 0;
        if (op == 2) begin
            check("R5", "compare flag", cmp_flag, flg);
            check("R5", "ready after compare", dec_ready, 1);
            check("R5", "exec closed", ex_valid, 0);
        end else begin
            check("R3", "stall hi write", dec_ready, 0);
            @(negedge clk);
            check("R3", "stall lo write", dec_ready, 0);
            @(negedge clk);
            check("R3", "ready after writes", dec_ready, 1);
            mrf[d] = res[63:32];
            mrf[d + 1 + doff] = res[31:0];
        end
    endtask

    task automatic run_bad(string why, logic [2:0] op, logic [31:0] w);
        @(negedge clk);
        dec_valid = 1; dec_op = op; dec_insn = w;
        @(negedge clk);
        dec_valid = 0;
        check("R7", {why, " trap"}, trap_illegal, 1);
        check("R7", {why, " no exec"}, ex_valid, 0);
        check("R7", {why, " ready"}, dec_ready, 1);
        @(negedge clk);
        check("R7", {why, " trap one cycle"}, trap_illegal, 0);
        check("R7", {why, " still no exec"}, ex_valid, 0);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog: actual hung expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 32; i++) mrf[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check("R9", "reset ready", dec_ready, 1);
        check("R9", "reset ex_valid", ex_valid, 0);
        check("R9", "reset trap", trap_illegal, 0);
        check("R9", "reset cmp_flag", cmp_flag, 0);

        // seed pairs through conversions (R6), spacing 1 and 2 (R1)
        run_op(3'd3, 2, 0, 0, 0, 0, 0, 64'h11111111_22222222, 0);
        run_op(3'd3, 4, 1, 0, 1, 0, 0, 64'hAAAA0001_BBBB0002, 0);
        // r5 skipped by spacing-2 pair: must still be zero (R1)
        run_op(3'd4, 29, 1, 4, 1, 0, 0, 64'h33333333_44444444, 0);   // partner = 31
        // arithmetic reading the skipped register and a spacing-2 B pair
        run_op(3'd0, 10, 0, 5, 0, 2, 1, 64'h55555555_66666666, 0);
        check("R1", "skipped reg r5 untouched", mrf[5], 32'h0);
        // multiply-add accumulates into destination pair (R4)
        run_op(3'd1, 2, 0, 29, 1, 4, 0, 64'h77777777_88888888, 0);
        run_op(3'd1, 4, 1, 10, 0, 2, 0, 64'h99999999_AAAAAAAA, 0);
        // compares (R5)
        run_op(3'd2, 0, 0, 30, 0, 10, 0, 64'hDEADBEEF_DEADBEEF, 1);
        run_op(3'd2, 0, 0, 2, 0, 4, 1, 64'h0, 0);

        // illegal encodings (R7, R5, R6)
        run_bad("dest partner 32", 3'd0, enc(30, 1, 0, 0, 0, 0));
        run_bad("A partner 32",    3'd0, enc(0, 0, 31, 0, 0, 0));
        run_bad("B partner 32",    3'd1, enc(0, 0, 0, 0, 30, 1));
        run_bad("cmp dest field",  3'd2, enc(1, 0, 2, 0, 4, 0));
        run_bad("cmp bit10",       3'd2, enc(0, 1, 2, 0, 4, 0));
        run_bad("conv B field",    3'd3, enc(2, 0, 4, 0, 3, 0));
        run_bad("conv bit8",       3'd4, enc(2, 0, 4, 0, 0, 1));
        run_bad("class code 6",    3'd6, enc(2, 0, 4, 0, 6, 0));

        // read back after traps: no register changed (R7); partner 31 boundary legal
        run_op(3'd0, 30, 0, 2, 0, 29, 1, 64'hCAFEF00D_12345678, 0);
        run_op(3'd0, 12, 1, 30, 0, 4, 1, 64'h0BADC0DE_0000FFFF, 0);
        run_op(3'd4, 20, 0, 12, 1, 0, 0, 64'h1, 0);
        run_op(3'd0, 0, 0, 20, 0, 0, 0, 64'h0, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule